// File: doc/BRIEF.md
# Programmable Chip-Select Wait-State Generator

This block sits beside a 16-bit processor's bus controller and turns each 20-bit bus address into one of six memory select lines. One window is anchored at the top of the 1 MB space, one is anchored at address zero, and a third window with a programmable base is split into four equal slices, each with its own select. When a region is hit, the block returns an internal ready after that region's programmed number of wait states. Each region can either also wait for the external ready input or ignore it. The CPU and the DMA engine use the same decode, because the block only sees the address, the memory/IO flag and the cycle strobe.

Software programs four write-only byte registers through a small port. The cycle begins on the first clock where `cyc_valid` is high while no cycle is active. On that edge, the block registers the selects and a copy of address bits 1 and 2 for slow peripherals. The selects stay up for as long as `cyc_valid` stays high.

Top module: `cs_wait_gen`

## Requirements
- R1: Register 0 sets the top window. Bits [2:0] are a size code k, giving a window of 1 KB<<k that ends at FFFFFh. Bits [4:3] are the wait count and bit 5 is the ignore-external-ready flag. Any memory address inside this window raises `cs_upper`.
- R2: After reset and before any write, the top window is 1 KB (FFC00h–FFFFFh, which covers FFFF0h) with 3 wait states, and external ready is required. The bottom and middle windows never match until they are enabled.
- R3: Register 1 uses the same fields as register 0, plus bit 6 as an enable. When enabled, a window of 1 KB<<k starting at 00000h raises `cs_lower`.
- R4: Register 2 holds the middle base address bits [19:12]. Register 3 uses the same fields as register 1, with a total middle size of 4 KB<<k. The base is aligned down to that size, and the window is split into four quarters. The quarter index, counted from the base, selects `cs_mid[index]`.
- R5: At most one select is high at any time. When windows overlap, the priority is top, then bottom, then middle.
- R6: Call the edge that starts a cycle E0. With a wait count w, and external ready allowed, `rdy_o` first goes high after edge E0+w.
- R7: When the ignore flag is clear, `rdy_o` also needs `ext_rdy` high. When the flag is set, `ext_rdy` has no effect.
- R8: An IO cycle, or a memory address outside every enabled window, raises no select. In that case `rdy_o` follows `ext_rdy` for the whole cycle.
- R9: `a1_q` and `a2_q` take address bits 1 and 2 at E0 and hold them until the next cycle starts.
- R10: The selects hold their value for the whole cycle. They clear on the edge that samples `cyc_valid` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_sel | input | 2 | Register index 0..3 |
| cfg_data | input | 8 | Register write data |
| cyc_addr | input | 20 | Bus cycle address |
| cyc_mem | input | 1 | 1 = memory cycle, 0 = IO cycle |
| cyc_valid | input | 1 | High for the length of a bus cycle |
| ext_rdy | input | 1 | External ready |
| cs_upper | output | 1 | Top-window select |
| cs_lower | output | 1 | Bottom-window select |
| cs_mid | output | 4 | Middle-window quarter selects |
| a1_q | output | 1 | Latched address bit 1 |
| a2_q | output | 1 | Latched address bit 2 |
| rdy_o | output | 1 | Ready returned to the bus controller |

## Verification
The bench probes the first and last byte of every window, and the bytes just outside them. A design that compares the window bounds off by one, or anchors a window at the wrong end, would give the wrong select there. Overlapping windows are programmed to check the priority, and removing the bottom window shows that the middle window was being masked rather than missing. Holding external ready low separates the two ready modes: a design that ignores the flag would either hang or return ready too early. The latched address bits are read after the cycle ends, which catches a latch that follows the live address.

// File: rtl/csw_pkg.sv
package csw_pkg;
  localparam int ADDR_W   = 20;
  localparam int SZ_W     = 3;
  localparam int WS_W     = 2;
  localparam int NMID     = 4;
  localparam int MID_IW   = $clog2(NMID);
  localparam int END_GRAN = 10;
  localparam int MID_GRAN = 12;
  localparam int BASE_W   = ADDR_W - MID_GRAN;

  typedef struct packed {
    logic [SZ_W-1:0] size;
    logic [WS_W-1:0] ws;
    logic            ign;
    logic            en;
  } rcfg_t;

  function automatic rcfg_t unpack_cfg(input logic [7:0] d);
    rcfg_t c;
    c.size = d[SZ_W-1:0];
    c.ws   = d[SZ_W+WS_W-1:SZ_W];
    c.ign  = d[5];
    c.en   = d[6];
    return c;
  endfunction

  function automatic logic [ADDR_W-1:0] span_mask(input int unsigned lsb_w,
                                                  input logic [SZ_W-1:0] code);
    logic [ADDR_W:0] bit_at;
    bit_at = (ADDR_W+1)'(1) << (lsb_w + int'(code));
    return bit_at[ADDR_W-1:0] - {{(ADDR_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic top_hit(input logic [ADDR_W-1:0] a, input logic [SZ_W-1:0] k);
    return &(a | span_mask(END_GRAN, k));
  endfunction

  function automatic logic bottom_hit(input logic [ADDR_W-1:0] a, input logic [SZ_W-1:0] k);
    return (a & ~span_mask(END_GRAN, k)) == '0;
  endfunction

  function automatic logic middle_hit(input logic [ADDR_W-1:0] a, input logic [BASE_W-1:0] b,
                                      input logic [SZ_W-1:0] k);
    return ((a ^ {b, {MID_GRAN{1'b0}}}) & ~span_mask(MID_GRAN, k)) == '0;
  endfunction

  function automatic logic [MID_IW-1:0] middle_slot(input logic [ADDR_W-1:0] a,
                                                    input logic [SZ_W-1:0] k);
    logic [ADDR_W-1:0] sh;
    sh = a >> (MID_GRAN + int'(k) - MID_IW);
    return sh[MID_IW-1:0];
  endfunction
endpackage

// File: rtl/csw_cfg.sv
module csw_cfg
  import csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [1:0]        sel,
  input  logic [7:0]        data,
  output rcfg_t             up_cfg,
  output rcfg_t             lo_cfg,
  output rcfg_t             md_cfg,
  output logic [BASE_W-1:0] md_base
);
  localparam rcfg_t UP_RESET = '{size: '0, ws: '1, ign: 1'b0, en: 1'b1};
  localparam rcfg_t OFF      = '{size: '0, ws: '0, ign: 1'b0, en: 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      up_cfg  <= UP_RESET;
      lo_cfg  <= OFF;
      md_cfg  <= OFF;
      md_base <= '0;
    end else if (we) begin
      case (sel)
        2'd0: begin
          up_cfg    <= unpack_cfg(data);
          up_cfg.en <= 1'b1;
        end
        2'd1: lo_cfg  <= unpack_cfg(data);
        2'd2: md_base <= data[BASE_W-1:0];
        default: md_cfg <= unpack_cfg(data);
      endcase
    end
  end
endmodule

// File: rtl/csw_decode.sv
module csw_decode
  import csw_pkg::*;
(
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_mem,
  input  rcfg_t             up_cfg,
  input  rcfg_t             lo_cfg,
  input  rcfg_t             md_cfg,
  input  logic [BASE_W-1:0] md_base,
  output logic              hit_up,
  output logic              hit_lo,
  output logic [NMID-1:0]   hit_md,
  output logic [WS_W-1:0]   win_ws,
  output logic              win_ign
);
  logic            up_raw, lo_raw, md_raw, md_win;
  logic [MID_IW-1:0] slot;

  assign up_raw = is_mem && top_hit(addr, up_cfg.size);
  assign lo_raw = is_mem && lo_cfg.en && bottom_hit(addr, lo_cfg.size);
  assign md_raw = is_mem && md_cfg.en && middle_hit(addr, md_base, md_cfg.size);
  assign slot   = middle_slot(addr, md_cfg.size);

  assign hit_up = up_raw;
  assign hit_lo = lo_raw && !up_raw;
  assign md_win = md_raw && !up_raw && !lo_raw;

  for (genvar g = 0; g < NMID; g++) begin : g_slot
    assign hit_md[g] = md_win && (slot == MID_IW'(g));
  end

  always_comb begin
    win_ws  = '0;
    win_ign = 1'b0;
    if (hit_up) begin
      win_ws  = up_cfg.ws;
      win_ign = up_cfg.ign;
    end else if (hit_lo) begin
      win_ws  = lo_cfg.ws;
      win_ign = lo_cfg.ign;
    end else if (md_win) begin
      win_ws  = md_cfg.ws;
      win_ign = md_cfg.ign;
    end
  end
endmodule

// File: rtl/csw_wait.sv
module csw_wait
  import csw_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            stop,
  input  logic [WS_W-1:0] ws_in,
  input  logic            ign_in,
  input  logic            ext_rdy,
  output logic            active,
  output logic            rdy
);
  logic [WS_W-1:0] wcnt;
  logic            ign_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      wcnt   <= '0;
      ign_q  <= 1'b0;
    end else if (start) begin
      active <= 1'b1;
      wcnt   <= ws_in;
      ign_q  <= ign_in;
    end else begin
      if (stop) active <= 1'b0;
      if (active && wcnt != '0) wcnt <= wcnt - 1'b1;
    end
  end

  assign rdy = active && (wcnt == '0) && (ign_q || ext_rdy);

  // R6
  count_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !stop && !start && wcnt != '0) |=> (wcnt == $past(wcnt) - 1'b1));
  // R6
  early_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && ws_in != '0) |=> !rdy);
endmodule

// File: rtl/cs_wait_gen.sv
module cs_wait_gen
  import csw_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [1:0]        cfg_sel,
  input  logic [7:0]        cfg_data,
  input  logic [ADDR_W-1:0] cyc_addr,
  input  logic              cyc_mem,
  input  logic              cyc_valid,
  input  logic              ext_rdy,
  output logic              cs_upper,
  output logic              cs_lower,
  output logic [NMID-1:0]   cs_mid,
  output logic              a1_q,
  output logic              a2_q,
  output logic              rdy_o
);
  rcfg_t             up_cfg, lo_cfg, md_cfg;
  logic [BASE_W-1:0] md_base;
  logic              hit_up, hit_lo, win_ign, active, start;
  logic [NMID-1:0]   hit_md;
  logic [WS_W-1:0]   win_ws;

  csw_cfg u_cfg (.clk(clk), .rst_n(rst_n), .we(cfg_we), .sel(cfg_sel), .data(cfg_data),
                 .up_cfg(up_cfg), .lo_cfg(lo_cfg), .md_cfg(md_cfg), .md_base(md_base));

  csw_decode u_dec (.addr(cyc_addr), .is_mem(cyc_mem), .up_cfg(up_cfg), .lo_cfg(lo_cfg),
                    .md_cfg(md_cfg), .md_base(md_base), .hit_up(hit_up), .hit_lo(hit_lo),
                    .hit_md(hit_md), .win_ws(win_ws), .win_ign(win_ign));

  assign start = cyc_valid && !active;

  csw_wait u_wait (.clk(clk), .rst_n(rst_n), .start(start), .stop(!cyc_valid),
                   .ws_in(win_ws), .ign_in(win_ign), .ext_rdy(ext_rdy),
                   .active(active), .rdy(rdy_o));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cs_upper <= 1'b0;
      cs_lower <= 1'b0;
      cs_mid   <= '0;
      a1_q     <= 1'b0;
      a2_q     <= 1'b0;
    end else if (start) begin
      cs_upper <= hit_up;
      cs_lower <= hit_lo;
      cs_mid   <= hit_md;
      a1_q     <= cyc_addr[1];
      a2_q     <= cyc_addr[2];
    end else if (!cyc_valid) begin
      cs_upper <= 1'b0;
      cs_lower <= 1'b0;
      cs_mid   <= '0;
    end
  end

  // R5
  one_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cs_upper, cs_lower, cs_mid}));
  // R10
  select_in_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_upper || cs_lower || cs_mid != '0) |-> active);
  // R8
  io_no_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !cyc_mem) |=> !(cs_upper || cs_lower || cs_mid != '0));
  // R9
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && cyc_valid) |=> $stable({a1_q, a2_q}));
endmodule

// File: tb/cs_wait_gen_test.sv
module cs_wait_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [1:0]  cfg_sel = '0;
  logic [7:0]  cfg_data = '0;
  logic [19:0] cyc_addr = '0;
  logic        cyc_mem = 1'b1;
  logic        cyc_valid = 1'b0;
  logic        ext_rdy = 1'b1;
  logic        cs_upper, cs_lower, a1_q, a2_q, rdy_o;
  logic [3:0]  cs_mid;
  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  cs_wait_gen uut (.clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
                   .cfg_data(cfg_data), .cyc_addr(cyc_addr), .cyc_mem(cyc_mem),
                   .cyc_valid(cyc_valid), .ext_rdy(ext_rdy), .cs_upper(cs_upper),
                   .cs_lower(cs_lower), .cs_mid(cs_mid), .a1_q(a1_q), .a2_q(a2_q), .rdy_o(rdy_o));

  typedef struct packed {
    logic [19:0] a;
    logic        m;
    logic [5:0]  s;
    logic [1:0]  w;
  } vec_t;

  // after: top 4KB ws1; bottom 8KB ws2; middle 64KB at 40000h ws0 ignore
  localparam int NV = 14;
  localparam vec_t VT [NV] = '{
    '{20'hFFFF0, 1'b1, 6'b100000, 2'd1},
    '{20'hFF000, 1'b1, 6'b100000, 2'd1},
    '{20'hFEFFF, 1'b1, 6'b000000, 2'd0},
    '{20'h00000, 1'b1, 6'b010000, 2'd2},
    '{20'h01FFF, 1'b1, 6'b010000, 2'd2},
    '{20'h02000, 1'b1, 6'b000000, 2'd0},
    '{20'h40000, 1'b1, 6'b000001, 2'd0},
    '{20'h47FFE, 1'b1, 6'b000010, 2'd0},
    '{20'h4A000, 1'b1, 6'b000100, 2'd0},
    '{20'h4FFFF, 1'b1, 6'b001000, 2'd0},
    '{20'h50000, 1'b1, 6'b000000, 2'd0},
    '{20'h3FFFF, 1'b1, 6'b000000, 2'd0},
    '{20'hFFFF0, 1'b0, 6'b000000, 2'd0},
    '{20'h00010, 1'b0, 6'b000000, 2'd0}
  };

  function automatic logic [5:0] selv();
    return {cs_upper, cs_lower, cs_mid};
  endfunction

  function automatic string tag_of(input logic [5:0] s);
    if (s[5]) return "R1";
    if (s[4]) return "R3";
    if (s[3:0] != 0) return "R4";
    return "R8";
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = s; cfg_data = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic do_cycle(input logic [19:0] a, input logic m, output logic [5:0] s1,
                          output logic [5:0] s_rdy, output int w, output logic [5:0] s_end);
    @(negedge clk);
    cyc_addr = a; cyc_mem = m; cyc_valid = 1'b1;
    w = -1; s1 = '0; s_rdy = '0;
    for (int j = 1; j <= 10; j++) begin
      @(negedge clk);
      if (j == 1) s1 = selv();
      if (rdy_o) begin
        w = j - 1;
        s_rdy = selv();
        break;
      end
    end
    cyc_valid = 1'b0;
    @(negedge clk);
    s_end = selv();
  endtask

  task automatic run_one(input logic [19:0] a, input logic m, input logic [5:0] es,
                         input int ew, input string req);
    logic [5:0] s1, sr, se;
    int w;
    do_cycle(a, m, s1, sr, w, se);
    chk(s1 == es, req, $sformatf("select @%05h", a), s1, es);
    chk(w == ew, "R6", $sformatf("wait count @%05h", a), w, ew);
    chk(sr == es && se == 6'd0, "R10", $sformatf("select hold/clear @%05h", a), {sr, se}, {es, 6'd0});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [5:0] s1, sr, se;
    int w;
    bit seen;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(selv() == 0 && !rdy_o && !a1_q && !a2_q, "R2", "reset outputs",
        {selv(), rdy_o, a1_q, a2_q}, 0);

    // R2 defaults: 1KB top window, ws3, others off
    run_one(20'hFFFF0, 1'b1, 6'b100000, 3, "R2");
    run_one(20'hFFC00, 1'b1, 6'b100000, 3, "R2");
    run_one(20'hFFBFF, 1'b1, 6'b000000, 0, "R2");
    run_one(20'h00000, 1'b1, 6'b000000, 0, "R2");
    run_one(20'h40000, 1'b1, 6'b000000, 0, "R2");

    wr(2'd0, 8'h0A);
    wr(2'd1, 8'h53);
    wr(2'd2, 8'h40);
    wr(2'd3, 8'h64);
    for (int i = 0; i < NV; i++)
      run_one(VT[i].a, VT[i].m, VT[i].s, int'(VT[i].w), tag_of(VT[i].s));

    // R7: bottom window needs external ready
    @(negedge clk);
    ext_rdy = 1'b0; cyc_addr = 20'h00100; cyc_mem = 1'b1; cyc_valid = 1'b1;
    seen = 1'b0;
    repeat (6) begin @(negedge clk); seen |= rdy_o; end
    chk(!seen, "R7", "ready without external ready", seen, 0);
    ext_rdy = 1'b1; #1;
    chk(rdy_o, "R7", "ready once external ready", rdy_o, 1);
    cyc_valid = 1'b0;
    @(negedge clk);

    // R7: middle window ignores external ready
    ext_rdy = 1'b0; cyc_addr = 20'h44000; cyc_valid = 1'b1;
    @(negedge clk);
    chk(rdy_o, "R7", "ignored external ready", rdy_o, 1);
    cyc_valid = 1'b0;
    @(negedge clk);

    // R8: unmatched follows external ready
    cyc_addr = 20'h80000; cyc_valid = 1'b1;
    seen = 1'b0;
    repeat (3) begin @(negedge clk); seen |= rdy_o; end
    chk(!seen, "R8", "unmatched ready low", seen, 0);
    ext_rdy = 1'b1; #1;
    chk(rdy_o, "R8", "unmatched ready follows", rdy_o, 1);
    cyc_valid = 1'b0;
    @(negedge clk);

    // R9: latched address bits
    do_cycle(20'h00004, 1'b1, s1, sr, w, se);
    chk(a2_q && !a1_q, "R9", "latched bits after 4", {a2_q, a1_q}, 2'b10);
    @(negedge clk);
    cyc_addr = 20'h00002; cyc_valid = 1'b1;
    @(negedge clk);
    cyc_addr = 20'h00004;
    @(negedge clk);
    chk(!a2_q && a1_q, "R9", "latched bits held mid-cycle", {a2_q, a1_q}, 2'b01);
    cyc_valid = 1'b0;
    @(negedge clk);

    // R5 priority
    wr(2'd1, 8'h47);
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h45);
    run_one(20'h10000, 1'b1, 6'b010000, 0, "R5");
    wr(2'd0, 8'h07);
    wr(2'd2, 8'hE0);
    wr(2'd3, 8'h43);
    run_one(20'hE0000, 1'b1, 6'b100000, 0, "R5");
    wr(2'd2, 8'h00);
    wr(2'd3, 8'h45);
    wr(2'd1, 8'h00);
    run_one(20'h10000, 1'b1, 6'b000100, 0, "R4");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule